// File: doc/BRIEF.md
# Self-Timed Page Program Engine

This block sits behind a serial memory front end and turns a decoded write command into programming of a 512 x 8 non-volatile array. When a write command opens, the block collects data bytes into a 16-byte page buffer. Each byte lands at the next offset inside the page that holds the start address. Deselect is reported together with the serial bit phase. If the deselect falls on a byte boundary and write permission is held, the block commits. It then runs a self-timed program cycle of fixed length in system clock cycles. During that cycle it drives the array write port, raises a busy flag, applies block protection, and at the end pulses a request that clears the external write enable latch. The same engine carries out status writes of the two protection bits.

The data byte input is a valid/ready stream. `in_ready` is held at 1, so the block never applies back-pressure. A serial source cannot stall, so a byte offered while no write is collecting is consumed and dropped. Command, deselect, permission and status pins are plain level or pulse signals.

Top module: `page_prog_engine`

## Requirements
- R1: After `cmd_start` with `cmd_sr`=0, each accepted byte goes to page offset (start offset + n) mod 16, where n counts bytes from 0. The page number is `cmd_addr[8:4]`. A later byte aimed at an offset that is already filled replaces the earlier one.
- R2: A `cs_rise` while collecting commits only if `bit_phase`=0 and the byte count is right: at least one byte for an array write, exactly one byte for a status write. Any other `cs_rise` cancels the command, with no array write and no busy cycle.
- R3: A commit also needs `wel`=1 at the deselect and `wp_n`=1 in every cycle from `cmd_start` through the deselect. Otherwise the command is cancelled.
- R4: `wip` rises in the cycle after the committing `cs_rise` edge and stays high for exactly PROG_CYCLES cycles.
- R5: `wel_clr` is a single-cycle pulse in the last cycle of `wip` after every committed cycle. It is never high at any other time.
- R6: In program cycle k (k = 0..15, where k = 0 is the first `wip` cycle), page offset k is written if it was filled and is not protected. The write port shows `mem_we`=1, `mem_addr`={page, k} and `mem_wdata` = the buffered byte. There are no array writes at any other time.
- R7: Protection by `bp`: 00 blocks nothing, 01 blocks 0x180 to 0x1FF, 10 blocks 0x100 to 0x1FF, 11 blocks all addresses. Blocked bytes are dropped one by one, and the other bytes of the same page are still written.
- R8: While `wip`=1, `cmd_start`, `in_valid` and `cs_rise` are ignored. The running cycle keeps its length and its writes.
- R9: A committed status write loads bits [3:2] of its data byte into `bp`[1:0]. `bp` keeps its old value for the whole cycle and takes the new value in the cycle after `wip` falls.
- R10: `bp` is 00 at power-up and keeps its value through `rst_n`.
- R11: `in_ready` is always 1. Bytes offered while no command is collecting are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (leaves `bp` alone) |
| cmd_start | input | 1 | Pulse: a write command opens |
| cmd_sr | input | 1 | With `cmd_start`: 1 = status write, 0 = array write |
| cmd_addr | input | 9 | With `cmd_start`: start byte address |
| in_valid | input | 1 | Data byte valid |
| in_ready | output | 1 | Data byte ready (constant 1) |
| in_data | input | 8 | Data byte |
| cs_rise | input | 1 | Pulse: chip deselected |
| bit_phase | input | 3 | With `cs_rise`: bits received of the current byte |
| wel | input | 1 | Write enable latch state |
| wp_n | input | 1 | Write-protect pin, low = protect |
| wel_clr | output | 1 | Pulse: clear the write enable latch |
| wip | output | 1 | Program cycle in progress |
| bp | output | 2 | Block protection bits |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 9 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
All results are timed from the clock edge that samples `cs_rise`. `wip` goes high one cycle later and lasts PROG_CYCLES cycles. The write for offset k appears k cycles after `wip` rises, `wel_clr` appears in the final `wip` cycle, and a new `bp` appears in the first cycle after `wip` falls. The bench drives just after a rising edge and samples every output at the falling edge. At each falling edge it counts the `wip` cycles since the rise and compares that count with the low address nibble of every write. After each command it waits out the whole window before it compares the captured array image, the `wip` length, the `wel_clr` count and `bp` against its own arithmetic model. It sweeps every protection setting, page-edge start offsets and lengths up to past one wrap.

// File: rtl/ppe_pkg.sv
`timescale 1ns/1ps
package ppe_pkg;
  typedef enum logic {ST_IDLE, ST_COLLECT} ppe_state_e;
endpackage

// File: rtl/ppe_protect.sv
`timescale 1ns/1ps
// Maps the protection bits onto a block signal for one array address.
module ppe_protect #(
  parameter int AW = 9
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    bp,
  output logic          blocked
);
  always_comb begin
    case (bp)
      2'b00:   blocked = 1'b0;
      2'b01:   blocked = &addr[AW-1:AW-2];
      2'b10:   blocked = addr[AW-1];
      default: blocked = 1'b1;
    endcase
  end
endmodule

// File: rtl/ppe_page_buf.sv
`timescale 1ns/1ps
// Page buffer: one register and one fill flag per slot, written at a
// wrapping pointer.
module ppe_page_buf #(
  parameter int SLOTS = 16,
  parameter int DW    = 8,
  localparam int OW   = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [OW-1:0] start_off,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic [OW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          rd_full
);
  logic [OW-1:0]    ptr_q;
  logic [SLOTS-1:0] full_q;
  logic [DW-1:0]    slot_q [SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (clear) begin
      ptr_q <= start_off;
    end else if (push) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q[s] <= 1'b0;
        slot_q[s] <= '0;
      end else if (clear) begin
        full_q[s] <= 1'b0;
      end else if (push && ptr_q == OW'(s)) begin
        full_q[s] <= 1'b1;
        slot_q[s] <= push_data;
      end
    end
  end

  assign rd_data = slot_q[rd_idx];
  assign rd_full = full_q[rd_idx];

  assert_ptr_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clear && (&ptr_q)) |=> (ptr_q == '0));
endmodule

// File: rtl/ppe_prog_timer.sv
`timescale 1ns/1ps
// Self-timed program cycle counter.
module ppe_prog_timer #(
  parameter int CYCLES = 2000000,
  parameter int SLOTS  = 16,
  localparam int OW    = $clog2(SLOTS),
  localparam int CW    = $clog2(CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [OW-1:0] step,
  output logic          step_live,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      cnt_q <= cnt_q + 1'b1;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end
  end

  assign last      = busy && (cnt_q == CW'(CYCLES - 1));
  assign step      = cnt_q[OW-1:0];
  assign step_live = busy && (cnt_q < CW'(SLOTS));

  assert_busy_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);
  assert_busy_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);
endmodule

// File: rtl/page_prog_engine.sv
`timescale 1ns/1ps
module page_prog_engine #(
  parameter int AW          = 9,
  parameter int DW          = 8,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 2000000,
  localparam int OW         = $clog2(PAGE_BYTES),
  localparam int PW         = AW - OW,
  localparam int NW         = OW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_sr,
  input  logic [AW-1:0] cmd_addr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          cs_rise,
  input  logic [2:0]    bit_phase,
  input  logic          wel,
  input  logic          wp_n,
  output logic          wel_clr,
  output logic          wip,
  output logic [1:0]    bp,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  import ppe_pkg::*;

  ppe_state_e    state_q;
  logic [PW-1:0] page_q;
  logic          is_sr_q, prog_sr_q, wp_seen_q;
  logic [NW-1:0] nbytes_q;
  logic [1:0]    sr_hold_q;
  logic [1:0]    bp_q = 2'b00;

  logic          busy, step_live, last, buf_full, blocked;
  logic [OW-1:0] step;
  logic [DW-1:0] buf_data;
  logic          open_cmd, push, count_ok, commit;

  assign in_ready = 1'b1;
  assign open_cmd = cmd_start && !busy;
  assign push     = (state_q == ST_COLLECT) && in_valid && !cs_rise && !cmd_start && !busy;
  assign count_ok = is_sr_q ? (nbytes_q == NW'(1)) : (nbytes_q != '0);
  assign commit   = (state_q == ST_COLLECT) && cs_rise && !busy && !cmd_start &&
                    (bit_phase == 3'd0) && count_ok && wel && wp_n && !wp_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      page_q    <= '0;
      is_sr_q   <= 1'b0;
      prog_sr_q <= 1'b0;
      wp_seen_q <= 1'b0;
      nbytes_q  <= '0;
      sr_hold_q <= 2'b00;
    end else if (open_cmd) begin
      state_q   <= ST_COLLECT;
      page_q    <= cmd_addr[AW-1:OW];
      is_sr_q   <= cmd_sr;
      wp_seen_q <= !wp_n;
      nbytes_q  <= '0;
    end else if (state_q == ST_COLLECT && !busy) begin
      if (!wp_n) wp_seen_q <= 1'b1;
      if (push) begin
        if (!(&nbytes_q)) nbytes_q <= nbytes_q + 1'b1;
        if (nbytes_q == '0) sr_hold_q <= in_data[3:2];
      end
      if (cs_rise) begin
        state_q <= ST_IDLE;
        if (commit) prog_sr_q <= is_sr_q;
      end
    end
  end

  // Non-volatile protection bits: power-up value only, untouched by rst_n.
  always_ff @(posedge clk) begin
    if (last && prog_sr_q) bp_q <= sr_hold_q;
  end
  assign bp = bp_q;

  ppe_page_buf #(.SLOTS(PAGE_BYTES), .DW(DW)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (open_cmd),
    .start_off (cmd_addr[OW-1:0]),
    .push      (push),
    .push_data (in_data),
    .rd_idx    (step),
    .rd_data   (buf_data),
    .rd_full   (buf_full)
  );

  ppe_prog_timer #(.CYCLES(PROG_CYCLES), .SLOTS(PAGE_BYTES)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (commit),
    .busy      (busy),
    .step      (step),
    .step_live (step_live),
    .last      (last)
  );

  ppe_protect #(.AW(AW)) u_prot (
    .addr    ({page_q, step}),
    .bp      (bp_q),
    .blocked (blocked)
  );

  assign wip       = busy;
  assign wel_clr   = last;
  assign mem_addr  = {page_q, step};
  assign mem_wdata = buf_data;
  assign mem_we    = step_live && buf_full && !blocked && !prog_sr_q;

  assert_we_in_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wip);
  assert_no_write_all_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (bp != 2'b11));
  assert_bp_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && $past(wip)) |-> $stable(bp));
  assert_wel_clr_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !wip);
  assert_wel_clr_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> wip);
endmodule

// File: tb/tb_page_prog_engine.sv
`timescale 1ns/1ps
module tb_page_prog_engine;
  localparam int PROG = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 0, cmd_sr = 0, in_valid = 0, cs_rise = 0, wel = 1, wp_n = 1;
  logic [8:0] cmd_addr = '0;
  logic [7:0] in_data = '0;
  logic [2:0] bit_phase = '0;
  logic in_ready, wel_clr, wip, mem_we;
  logic [1:0] bp;
  logic [8:0] mem_addr;
  logic [7:0] mem_wdata;

  always #2.5 clk = ~clk;

  page_prog_engine #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_sr(cmd_sr),
    .cmd_addr(cmd_addr), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cs_rise(cs_rise), .bit_phase(bit_phase), .wel(wel),
    .wp_n(wp_n), .wel_clr(wel_clr), .wip(wip), .bp(bp), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] obs [512];
  logic [7:0] exp_m [512];
  int wip_cnt, wel_cnt, slot_bad, wel_late, wip_k;
  logic wip_prev = 0, wel_pend = 0;

  // Write port and status monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (wip) begin
      wip_k = wip_prev ? wip_k + 1 : 0;
      wip_cnt++;
    end
    if (mem_we) begin
      obs[mem_addr] = mem_wdata;
      if (!wip || int'(mem_addr[3:0]) != wip_k) slot_bad++;
    end
    if (wel_pend && wip) wel_late++;
    wel_pend = wel_clr;
    if (wel_clr) begin
      wel_cnt++;
      if (!wip) wel_late++;
    end
    wip_prev = wip;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic bit prot(input int a, input int b);
    case (b)
      0: return 0;
      1: return a >= 384;
      2: return a >= 256;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] dbyte(input int seed, input int i);
    return 8'((seed * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic tick;
    @(posedge clk); #1;
  endtask

  // One command: open, n bytes, deselect at the given phase
  task automatic run_cmd(input bit sr, input int addr, input int n, input int seed,
                         input int phase, input bit wl, input bit wp_dip,
                         input bit disturb, input bit mid_bp_chk, input int bp_old);
    wip_cnt = 0; wel_cnt = 0; slot_bad = 0; wel_late = 0;
    wel = wl;
    cmd_start = 1; cmd_sr = sr; cmd_addr = 9'(addr);
    tick;
    cmd_start = 0;
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_data = dbyte(seed, i);
      wp_n = !(wp_dip && i == 0);
      tick;
    end
    in_valid = 0; wp_n = 1;
    cs_rise = 1; bit_phase = 3'(phase);
    tick;
    cs_rise = 0; bit_phase = 0;
    if (disturb) begin
      repeat (3) tick;
      cmd_start = 1; cmd_sr = 0; cmd_addr = 9'h0A0;
      tick;
      cmd_start = 0; in_valid = 1; in_data = 8'h5A;
      repeat (3) tick;
      in_valid = 0; cs_rise = 1;
      tick;
      cs_rise = 0;
    end
    if (mid_bp_chk) begin
      repeat (6) @(negedge clk);
      check(bp == 2'(bp_old), "R9 bp frozen mid-cycle", bp, bp_old);
      #1;
    end
    repeat (PROG + 6) tick;
  endtask

  task automatic model_write(input int addr, input int n, input int seed, input int b);
    logic [7:0] tmp [16];
    bit have [16];
    int page = addr / 16;
    for (int o = 0; o < 16; o++) have[o] = 0;
    for (int i = 0; i < n; i++) begin
      tmp[(addr + i) % 16] = dbyte(seed, i);
      have[(addr + i) % 16] = 1;
    end
    for (int o = 0; o < 16; o++)
      if (have[o] && !prot(page * 16 + o, b)) exp_m[page * 16 + o] = tmp[o];
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0, first = -1;
    for (int a = 0; a < 512; a++)
      if (obs[a] !== exp_m[a]) begin
        bad++;
        if (first < 0) first = a;
      end
    if (first < 0) check(1, req, 0, 0);
    else check(0, req, obs[first], exp_m[first]);
  endtask

  task automatic chk_cycle(input bit committed, input string req);
    check(wip_cnt == (committed ? PROG : 0), {req, " R4 wip length"}, wip_cnt,
          committed ? PROG : 0);
    check(wel_cnt == (committed ? 1 : 0) && wel_late == 0, {req, " R5 wel_clr"},
          wel_cnt, committed ? 1 : 0);
    check(slot_bad == 0, {req, " R6 write slot timing"}, slot_bad, 0);
  endtask

  task automatic set_bp(input int b);
    int cur = bp;
    run_cmd(1, 0, 1, 0, 0, 1, 0, 0, 1, cur);
    // Override seed byte: use direct drive for the status value
  endtask

  task automatic sr_write(input int b, input int n, input int phase, input bit ok);
    int old = bp;
    wip_cnt = 0; wel_cnt = 0; slot_bad = 0; wel_late = 0;
    wel = 1;
    cmd_start = 1; cmd_sr = 1; cmd_addr = 9'h1FF;
    tick;
    cmd_start = 0;
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_data = {4'hA, 2'(b), 2'b01};
      tick;
    end
    in_valid = 0; cs_rise = 1; bit_phase = 3'(phase);
    tick;
    cs_rise = 0; bit_phase = 0;
    if (ok) begin
      repeat (6) @(negedge clk);
      check(bp == 2'(old), "R9 bp frozen during cycle", bp, old);
      #1;
    end
    repeat (PROG + 6) tick;
    check(bp == 2'(ok ? b : old), ok ? "R9 bp loaded" : "R2 status write cancelled",
          bp, ok ? b : old);
    chk_cycle(ok, "R9");
    cmp_mem("R9 status write leaves array");
  endtask

  initial begin
    for (int a = 0; a < 512; a++) begin obs[a] = 8'hFF; exp_m[a] = 8'hFF; end
    @(negedge clk);
    check(bp == 2'b00, "R10 bp power-up", bp, 0);
    check(wip == 0 && mem_we == 0 && wel_clr == 0, "R4 reset state", wip, 0);
    repeat (3) tick;
    rst_n = 1;
    tick;
    check(in_ready == 1'b1, "R11 in_ready", in_ready, 1);

    // R11: stray bytes with no command are dropped
    in_valid = 1; in_data = 8'h33;
    repeat (4) tick;
    in_valid = 0;
    cs_rise = 1; tick; cs_rise = 0;
    repeat (4) tick;
    check(wip_cnt == 0, "R11 stray bytes no cycle", wip_cnt, 0);
    cmp_mem("R11 stray bytes dropped");

    // Sweep protection setting x start address x length
    begin
      int addrs [6] = '{0, 11, 383, 384, 501, 256};
      int lens  [4] = '{1, 5, 16, 20};
      int seed = 1;
      for (int b = 0; b < 4; b++) begin
        sr_write(b, 1, 0, 1);
        for (int ai = 0; ai < 6; ai++)
          for (int li = 0; li < 4; li++) begin
            run_cmd(0, addrs[ai], lens[li], seed, 0, 1, 0, 0, 0, 0);
            model_write(addrs[ai], lens[li], seed, b);
            chk_cycle(1, "R1");
            cmp_mem(b == 0 ? "R1 page wrap and overwrite" : "R7 protection map");
            seed++;
          end
      end
      sr_write(0, 1, 0, 1);

      // R2: deselect off a byte boundary, and with no data bytes
      for (int ph = 1; ph < 8; ph++) begin
        run_cmd(0, 64, 3, seed, ph, 1, 0, 0, 0, 0);
        chk_cycle(0, "R2 bad phase");
        cmp_mem("R2 bad phase cancels");
      end
      run_cmd(0, 64, 0, seed, 0, 1, 0, 0, 0, 0);
      chk_cycle(0, "R2 no bytes");
      cmp_mem("R2 no bytes cancels");
      sr_write(3, 2, 0, 0);
      sr_write(3, 0, 0, 0);
      sr_write(2, 1, 4, 0);

      // R3: latch clear, and protect pin dipping during collection
      run_cmd(0, 80, 4, seed, 0, 0, 0, 0, 0, 0);
      chk_cycle(0, "R3 wel low");
      cmp_mem("R3 wel low cancels");
      run_cmd(0, 80, 4, seed, 0, 1, 1, 0, 0, 0);
      chk_cycle(0, "R3 wp dip");
      cmp_mem("R3 wp dip cancels");

      // R8: command traffic during a program cycle
      run_cmd(0, 200, 6, seed, 0, 1, 0, 1, 0, 0);
      model_write(200, 6, seed, 0);
      chk_cycle(1, "R8");
      cmp_mem("R8 traffic in cycle ignored");

      // R10: reset keeps bp
      sr_write(2, 1, 0, 1);
      rst_n = 0; repeat (3) tick; rst_n = 1; tick;
      check(bp == 2'b10, "R10 bp kept over reset", bp, 2);
      check(wip == 0, "R4 idle after reset", wip, 0);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule